// File: doc/BRIEF.md
# Flash Block Page Program Order Tracker

This block follows the program commands issued to one erase block of a two-bit-per-cell flash array. Each page number is decoded into a wordline index and a bit role, either the lower bit or the upper bit of the cells on that wordline. The numbering is interleaved. Wordline 0 holds pages 0 and 2. Every later wordline n holds lower page 2n−1 and upper page 2n+2. The decode is combinational and available on every cycle.

Each accepted program command updates a per-wordline record of which halves are written. A command is checked against a selectable ordering policy, and a rejected command raises a one-cycle error and changes nothing. For each wordline the block also keeps a disturb count: the number of accepted programs on the wordlines directly above and below that happened after both halves of that wordline were written. A controller reads this count through a query port, so it can estimate how far the stored threshold voltages of that wordline have moved.

Top module: `pgtrk_order_tracker`

## Requirements
- R1: The decode outputs for `prog_page` follow this mapping. Page 0 is wordline 0 lower (`map_upper`=0), and page 2 is wordline 0 upper. For n ≥ 1, page 2n−1 is wordline n lower and page 2n+2 is wordline n upper. `map_valid` is 1 exactly when the decoded wordline is below NUM_WL.
- R2: A command is rejected in these cases: it writes a page that is already written, or it writes an upper page whose lower page is not yet written. On rejection, `order_err` is 1 in the cycle after the command, and all per-wordline state and the accepted-page count are unchanged.
- R3: With `policy`=0 (page order), the k-th accepted page must be page k, except that page 2·NUM_WL follows page 2·NUM_WL−2. Any other page is rejected.
- R4: With `policy`=1 (wordline order), the k-th accepted page must be page 0 for k=0, page k+1 for odd k, and page k−1 for even k>0. Any other page is rejected.
- R5: With `policy`=2 or 3 (unrestricted), any valid page that is not rejected under R2 is accepted, in any order.
- R6: When a program on wordline w is accepted, the disturb count of wordline w−1 and of wordline w+1 goes up by one, but only for a wordline whose upper half was already written before that command. The count never exceeds 4.
- R7: `query_lower`, `query_upper` and `query_count` show the state of wordline `query_wl`. They are combinational from the stored state, so an update is visible in the cycle after the accepting edge.
- R8: `erase` clears every flag, every count, the accepted-page count and `order_err` at the next edge. A program command in the same cycle is dropped, with no error.
- R9: A page whose decoded wordline is not below NUM_WL (for example page 2·NUM_WL−1) is rejected with `order_err`.
- R10: `order_err` stays high for one cycle only, unless the next command is also rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase | input | 1 | Synchronous block erase; clears all tracking state |
| policy | input | 2 | Ordering policy: 0 page order, 1 wordline order, 2/3 unrestricted |
| prog_valid | input | 1 | A program command is present this cycle |
| prog_page | input | PAGE_W | Page number of the command; also drives the decode |
| map_wl | output | WL_W | Wordline decoded from `prog_page` |
| map_upper | output | 1 | 1 when `prog_page` is an upper-bit page |
| map_valid | output | 1 | 1 when the decoded wordline exists |
| order_err | output | 1 | Registered pulse for a rejected command |
| query_wl | input | WL_W | Wordline to report |
| query_lower | output | 1 | Lower half of `query_wl` written |
| query_upper | output | 1 | Upper half of `query_wl` written |
| query_count | output | 3 | Disturb count of `query_wl` |

## Verification
The bench targets the irregular decode at wordline 0 and at the top of the range. A wrong decode would accept page 2·NUM_WL−1 or place pages 0 and 2 on the wrong wordline. It also checks the jump from page 2·NUM_WL−2 to 2·NUM_WL under page order; a design that missed this jump would lock the last upper page out. It builds an out-of-order sequence that drives one wordline's count to 4 and programs a neighbour before its victim is complete. A design that counted too early would report counts under page order that are not 1, or counts under wordline order that are not 2. Erase arriving together with a program, duplicate writes and upper-before-lower writes are each checked. The checks look for state that changes when it should not and for a missing or stretched error pulse.

// File: rtl/pgtrk_pkg.sv
package pgtrk_pkg;

   typedef enum logic [1:0] {
      POL_PAGE   = 2'd0,
      POL_WL     = 2'd1,
      POL_FREE_A = 2'd2,
      POL_FREE_B = 2'd3
   } order_pol_e;

   localparam int unsigned DISTURB_W   = 3;
   localparam int unsigned DISTURB_MAX = 4;

endpackage

// File: rtl/pgtrk_page_map.sv
module pgtrk_page_map #(
   parameter int unsigned NUM_WL = 64,
   parameter int unsigned PAGE_W = $clog2(2 * NUM_WL + 1),
   parameter int unsigned WL_W   = $clog2(NUM_WL)
) (
   input  logic [PAGE_W-1:0] page,
   output logic [WL_W-1:0]   wl,
   output logic              upper,
   output logic              valid
);

   localparam int unsigned IW = PAGE_W + 1;

   logic [IW-1:0] ext;
   logic [IW-1:0] idx;

   always_comb begin
      ext   = {1'b0, page};
      idx   = '0;
      upper = 1'b0;
      if (page == '0) begin
         idx   = '0;
         upper = 1'b0;
      end else if (page == PAGE_W'(2)) begin
         idx   = '0;
         upper = 1'b1;
      end else if (page[0]) begin
         idx   = (ext + IW'(1)) >> 1;
         upper = 1'b0;
      end else begin
         idx   = (ext - IW'(2)) >> 1;
         upper = 1'b1;
      end
      valid = (idx < IW'(NUM_WL));
      wl    = idx[WL_W-1:0];
   end

endmodule

// File: rtl/pgtrk_order_seq.sv
module pgtrk_order_seq
   import pgtrk_pkg::*;
#(
   parameter int unsigned NUM_WL = 64,
   parameter int unsigned PAGE_W = $clog2(2 * NUM_WL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              advance,
   input  order_pol_e        policy,
   output logic [PAGE_W-1:0] exp_page
);

   localparam logic [PAGE_W-1:0] LAST_LOW_SLOT = PAGE_W'(2 * NUM_WL - 1);
   localparam logic [PAGE_W-1:0] TOP_PAGE      = PAGE_W'(2 * NUM_WL);

   logic [PAGE_W-1:0] done_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_cnt <= '0;
      end else if (erase) begin
         done_cnt <= '0;
      end else if (advance) begin
         done_cnt <= done_cnt + PAGE_W'(1);
      end
   end

   always_comb begin
      unique case (policy)
         POL_PAGE: exp_page = (done_cnt == LAST_LOW_SLOT) ? TOP_PAGE : done_cnt;
         POL_WL: begin
            if (done_cnt == '0)    exp_page = '0;
            else if (done_cnt[0])  exp_page = done_cnt + PAGE_W'(1);
            else                   exp_page = done_cnt - PAGE_W'(1);
         end
         default:  exp_page = done_cnt;
      endcase
   end

   assert_seq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!erase && !advance) |=> $stable(done_cnt));

   assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!erase && advance) |=> (done_cnt == $past(done_cnt) + PAGE_W'(1)));

   assert_seq_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_cnt <= TOP_PAGE);

endmodule

// File: rtl/pgtrk_wl_state.sv
module pgtrk_wl_state
   import pgtrk_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 erase,
   input  logic                 set_lo,
   input  logic                 set_up,
   input  logic                 nb_hit,
   output logic                 lo_done,
   output logic                 up_done,
   output logic [DISTURB_W-1:0] disturb
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_done <= 1'b0;
         up_done <= 1'b0;
         disturb <= '0;
      end else if (erase) begin
         lo_done <= 1'b0;
         up_done <= 1'b0;
         disturb <= '0;
      end else begin
         if (set_lo) lo_done <= 1'b1;
         if (set_up) up_done <= 1'b1;
         if (nb_hit && up_done && (disturb < DISTURB_W'(DISTURB_MAX)))
            disturb <= disturb + DISTURB_W'(1);
      end
   end

   assert_lower_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      up_done |-> lo_done);

   assert_count_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (disturb != '0) |-> up_done);

   assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      disturb <= DISTURB_W'(DISTURB_MAX));

   assert_erase_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (!lo_done && !up_done && disturb == '0));

endmodule

// File: rtl/pgtrk_order_tracker.sv
module pgtrk_order_tracker
   import pgtrk_pkg::*;
#(
   parameter int unsigned NUM_WL = 64,
   parameter int unsigned PAGE_W = $clog2(2 * NUM_WL + 1),
   parameter int unsigned WL_W   = $clog2(NUM_WL)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 erase,
   input  logic [1:0]           policy,
   input  logic                 prog_valid,
   input  logic [PAGE_W-1:0]    prog_page,
   output logic [WL_W-1:0]      map_wl,
   output logic                 map_upper,
   output logic                 map_valid,
   output logic                 order_err,
   input  logic [WL_W-1:0]      query_wl,
   output logic                 query_lower,
   output logic                 query_upper,
   output logic [DISTURB_W-1:0] query_count
);

   localparam int unsigned QW = WL_W + 1;

   if (NUM_WL < 2) begin : g_bad_wl
      $error("pgtrk_order_tracker: NUM_WL must be at least 2");
   end
   if (PAGE_W < $clog2(2 * NUM_WL + 1)) begin : g_bad_pw
      $error("pgtrk_order_tracker: PAGE_W too narrow for the page range");
   end
   if (WL_W < $clog2(NUM_WL)) begin : g_bad_ww
      $error("pgtrk_order_tracker: WL_W too narrow for NUM_WL");
   end

   order_pol_e            pol;
   logic [PAGE_W-1:0]     exp_page;
   logic [NUM_WL-1:0]     lo_v;
   logic [NUM_WL-1:0]     up_v;
   logic [DISTURB_W-1:0]  cnt_a [NUM_WL];
   logic                  sel_lo;
   logic                  sel_up;
   logic                  reject;
   logic                  accept;
   logic                  ordered;

   assign pol = order_pol_e'(policy);

   pgtrk_page_map #(.NUM_WL(NUM_WL), .PAGE_W(PAGE_W), .WL_W(WL_W)) u_map (
      .page  (prog_page),
      .wl    (map_wl),
      .upper (map_upper),
      .valid (map_valid)
   );

   pgtrk_order_seq #(.NUM_WL(NUM_WL), .PAGE_W(PAGE_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .erase    (erase),
      .advance  (accept),
      .policy   (pol),
      .exp_page (exp_page)
   );

   always_comb begin
      sel_lo = 1'b0;
      sel_up = 1'b0;
      if (map_valid) begin
         sel_lo = lo_v[map_wl];
         sel_up = up_v[map_wl];
      end
      ordered = (pol == POL_PAGE) || (pol == POL_WL);
      reject  = !map_valid
             || (map_upper ? (!sel_lo || sel_up) : sel_lo)
             || (ordered && (prog_page != exp_page));
      accept  = prog_valid && !erase && !reject;
   end

   for (genvar i = 0; i < NUM_WL; i++) begin : g_wl
      logic hit_below;
      logic hit_above;
      logic self_hit;

      if (i > 0) begin : g_below
         assign hit_below = (map_wl == WL_W'(i - 1));
      end else begin : g_no_below
         assign hit_below = 1'b0;
      end

      if (i < NUM_WL - 1) begin : g_above
         assign hit_above = (map_wl == WL_W'(i + 1));
      end else begin : g_no_above
         assign hit_above = 1'b0;
      end

      assign self_hit = (map_wl == WL_W'(i));

      pgtrk_wl_state u_state (
         .clk     (clk),
         .rst_n   (rst_n),
         .erase   (erase),
         .set_lo  (accept && !map_upper && self_hit),
         .set_up  (accept && map_upper && self_hit),
         .nb_hit  (accept && (hit_below || hit_above)),
         .lo_done (lo_v[i]),
         .up_done (up_v[i]),
         .disturb (cnt_a[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         order_err <= 1'b0;
      end else begin
         order_err <= prog_valid && !erase && reject;
      end
   end

   always_comb begin
      query_lower = 1'b0;
      query_upper = 1'b0;
      query_count = '0;
      if ({1'b0, query_wl} < QW'(NUM_WL)) begin
         query_lower = lo_v[query_wl];
         query_upper = up_v[query_wl];
         query_count = cnt_a[query_wl];
      end
   end

   assert_bad_page_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_valid && !erase && !map_valid) |=> order_err);

   assert_erase_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> !order_err);

   assert_idle_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_valid |=> !order_err);

   assert_dup_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_valid && !erase && map_valid && !map_upper && sel_lo) |=> order_err);

endmodule

// File: tb/test_pgtrk_order_tracker.sv
`timescale 1ns/1ps
module test_pgtrk_order_tracker;

   localparam int NWL = 8;
   localparam int PW  = $clog2(2 * NWL + 1);
   localparam int WW  = $clog2(NWL);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          erase = 1'b0;
   logic [1:0]    policy = 2'd0;
   logic          prog_valid = 1'b0;
   logic [PW-1:0] prog_page = '0;
   logic [WW-1:0] map_wl;
   logic          map_upper;
   logic          map_valid;
   logic          order_err;
   logic [WW-1:0] query_wl = '0;
   logic          query_lower;
   logic          query_upper;
   logic [2:0]    query_count;

   always #2.5 clk = ~clk;

   pgtrk_order_tracker #(.NUM_WL(NWL)) i_pgtrk_order_tracker (
      .clk(clk), .rst_n(rst_n), .erase(erase), .policy(policy),
      .prog_valid(prog_valid), .prog_page(prog_page),
      .map_wl(map_wl), .map_upper(map_upper), .map_valid(map_valid),
      .order_err(order_err), .query_wl(query_wl),
      .query_lower(query_lower), .query_upper(query_upper),
      .query_count(query_count)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   bit mlo [NWL];
   bit mup [NWL];
   int mcnt [NWL];
   int mk = 0;

   function automatic int page_of(int w, bit up);
      if (w == 0) return up ? 2 : 0;
      return up ? 2 * w + 2 : 2 * w - 1;
   endfunction

   function automatic void decode(int p, output int w, output bit up, output bit v);
      w = 0; up = 0; v = 0;
      for (int i = 0; i < NWL; i++)
         for (int b = 0; b < 2; b++)
            if (page_of(i, b[0]) == p) begin w = i; up = b[0]; v = 1; end
   endfunction

   function automatic int exp_next(int pol, int k);
      if (pol == 0) return (k == 2 * NWL - 1) ? 2 * NWL : k;
      if (k == 0) return 0;
      return (k % 2 == 1) ? k + 1 : k - 1;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NWL; i++) begin mlo[i] = 0; mup[i] = 0; mcnt[i] = 0; end
      mk = 0;
   endtask

   task automatic chk_q(int w, string req);
      query_wl = w[WW-1:0];
      #1;
      chk(query_lower == mlo[w], req, int'(query_lower), int'(mlo[w]));
      chk(query_upper == mup[w], req, int'(query_upper), int'(mup[w]));
      chk(int'(query_count) == mcnt[w], req, int'(query_count), mcnt[w]);
   endtask

   task automatic prog(int p, int pol, string req);
      int w; bit u, v, rej;
      policy = pol[1:0];
      prog_page = p[PW-1:0];
      prog_valid = 1'b1;
      decode(p, w, u, v);
      rej = !v;
      if (v) rej = rej || (u ? (!mlo[w] || mup[w]) : mlo[w]);
      if (pol < 2 && p != exp_next(pol, mk)) rej = 1;
      @(posedge clk);
      @(negedge clk);
      prog_valid = 1'b0;
      if (!rej) begin
         if (w > 0 && mup[w-1] && mcnt[w-1] < 4) mcnt[w-1]++;
         if (w < NWL - 1 && mup[w+1] && mcnt[w+1] < 4) mcnt[w+1]++;
         if (u) mup[w] = 1; else mlo[w] = 1;
         mk++;
      end
      chk(order_err == rej, req, int'(order_err), int'(rej));
   endtask

   task automatic do_erase(bit with_prog);
      erase = 1'b1;
      prog_valid = with_prog;
      prog_page = '0;
      @(posedge clk);
      @(negedge clk);
      erase = 1'b0;
      prog_valid = 1'b0;
      model_clear();
      chk(order_err == 0, "R8", int'(order_err), 0);
   endtask

   task automatic idle_err_check();
      @(posedge clk);
      @(negedge clk);
      chk(order_err == 0, "R10", int'(order_err), 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      model_clear();
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 reset state
      chk(order_err == 0, "R7", int'(order_err), 0);
      for (int i = 0; i < NWL; i++) chk_q(i, "R7");

      // R1 decode sweep, prog_valid low
      for (int p = 0; p < 2 * NWL + 3; p++) begin
         int w; bit u, v;
         decode(p, w, u, v);
         prog_page = p[PW-1:0];
         #1;
         chk(map_valid == v, "R1", int'(map_valid), int'(v));
         if (v) begin
            chk(int'(map_wl) == w, "R1", int'(map_wl), w);
            chk(map_upper == u, "R1", int'(map_upper), int'(u));
         end
      end
      chk_q(0, "R1");

      // R3 page order: skip rejected, then whole block
      prog(1, 0, "R3");
      idle_err_check();
      for (int k = 0; k < 2 * NWL; k++) prog(exp_next(0, k), 0, "R3");
      for (int i = 0; i < NWL; i++) begin
         chk_q(i, "R6");
         chk(int'(query_count) == ((i < NWL - 1) ? 1 : 0), "R6", int'(query_count),
             (i < NWL - 1) ? 1 : 0);
      end
      prog(0, 2, "R2");

      // R8 erase with a same-cycle program
      do_erase(1'b1);
      for (int i = 0; i < NWL; i++) chk_q(i, "R8");

      // R4 wordline order
      prog(0, 1, "R4");
      prog(1, 1, "R4");
      for (int k = 1; k < 2 * NWL; k++) prog(exp_next(1, k), 1, "R4");
      for (int i = 0; i < NWL; i++) begin
         chk_q(i, "R6");
         chk(int'(query_count) == ((i < NWL - 1) ? 2 : 0), "R6", int'(query_count),
             (i < NWL - 1) ? 2 : 0);
      end
      do_erase(1'b0);

      // R5 unrestricted: victim wordline 2 reaches 4
      prog(4, 2, "R2");
      prog(3, 3, "R5");
      prog(3, 2, "R2");
      prog(6, 2, "R5");
      prog(1, 2, "R5");
      prog(4, 2, "R5");
      prog(5, 3, "R5");
      prog(8, 2, "R5");
      prog(2 * NWL - 1, 2, "R9");
      prog(2 * NWL + 2, 2, "R9");
      idle_err_check();
      for (int i = 0; i < NWL; i++) chk_q(i, "R6");
      query_wl = WW'(2);
      #1;
      chk(query_count == 3'd4, "R6", int'(query_count), 4);
      do_erase(1'b0);

      // random mix
      begin
         int pol = 0;
         for (int it = 0; it < 3000; it++) begin
            int r = int'($urandom % 100);
            if (r < 2) begin
               do_erase(r[0]);
               pol = int'($urandom % 4);
            end else begin
               int p;
               if (pol < 2 && r < 80 && mk < 2 * NWL) p = exp_next(pol, mk);
               else p = int'($urandom % (2 * NWL + 3));
               prog(p, pol, (pol == 0) ? "R3" : (pol == 1) ? "R4" : "R5");
               if (mk >= 2 * NWL && r > 90) begin
                  do_erase(1'b0);
                  pol = int'($urandom % 4);
               end
            end
            chk_q(int'($urandom % NWL), "R6");
         end
      end

      finish_run();
   end

endmodule